// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the serial front end of a small on-chip byte store of up to two 256-byte blocks. It watches a clock line and a data line that have already been synchronized to the fast system clock. It pulls the data line low through an open-drain enable. From the line activity it recognizes bus start and stop conditions, decodes the control byte, and acknowledges received bytes. It also keeps a word pointer and streams stored bytes out to the master.

Write data is not stored here. Each received data byte goes out on a one-cycle strobe, together with its full array address, to a separate page-program sequencer. That sequencer reports back through a busy input. While busy is high, the engine acknowledges nothing, including its own control byte, so a master can poll for the end of a program cycle. The memory read port is combinational: the engine presents an address and takes the byte back in the same cycle.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A start condition (data falling while clock is high) restarts control-byte reception from bit zero in any state, including in the middle of a byte. A stop condition (data rising while clock is high) returns the engine to idle with the data line released.
- R2: The control byte arrives MSB first. Bits 7..4 must equal 4'b1010, bits 3..1 are chip-select bits compared with strap_i[2:0] (bit 3 against strap_i[2]), and bit 0 is the direction (0 write, 1 read). A byte with any other device code is not acknowledged.
- R3: The engine changes sda_oe only while the clock line is low.
- R4: After a matching control byte, a word-address byte, or a write-data byte, sda_oe is 1 from the falling clock edge that ends bit 8 until the falling edge that ends the ninth clock. The master therefore reads a low acknowledge during the ninth high phase.
- R5: If prog_busy_i is 1 when a received byte completes, that byte is not acknowledged and the engine ignores the bus until the next start or stop. No write strobe is issued for that byte.
- R6: A control byte whose chip-select bits do not match is not acknowledged. The engine then keeps sda_oe at 0 and issues no write strobe until the next start or stop.
- R7: The first byte after a write control byte loads the low 8 bits of the word pointer. Each later byte pulses wr_valid_o for one cycle, with wr_data_o set to the byte and mem_addr_o set to {block, pointer}. The pointer then increments.
- R8: In a read, the byte at {block, pointer} is shifted out MSB first and the pointer increments. The next byte follows only if the master drives a low acknowledge. After a high acknowledge the data line stays released.
- R9: A random read is a word-address write followed by a repeated start and a read control byte. A read control byte without a preceding address write starts from the current pointer.
- R10: The pointer increments modulo 256 and never changes the block bit, so address 0xFF of a block is followed by 0x00 of the same block.
- R11: With TWO_BLOCK=1, control bit 1 selects the block (mem_addr_o[8]) and strap_i[0] takes no part in the match.
- R12: A stop that ends a frame in which at least one write strobe occurred pulses wr_end_o for one cycle. Other stops do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Chip-select strap levels |
| prog_busy_i | input | 1 | Program sequencer busy |
| mem_addr_o | output | PTR_W+1 | Array address {block, pointer} for reads and writes |
| mem_rdata_i | input | 8 | Array byte at mem_addr_o |
| wr_valid_o | output | 1 | One-cycle strobe: write byte available |
| wr_data_o | output | 8 | Write data byte |
| wr_end_o | output | 1 | One-cycle strobe: write frame closed by stop |

## Verification
The functions most likely to meet in one cycle are pointer increment and block selection at the 0xFF boundary, and byte completion and the busy flag. The bench writes and reads across offset 0xFF in block 1 and in block 0 and judges the delivered addresses and returned bytes against its own shadow array. It also raises busy before a control byte and checks that the acknowledge slot reads high and no strobe appears. A seeded random mix of write and read bursts at random blocks and offsets covers the rest.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_CTRL,
    S_CTRL_ACK,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_DATA_ACK,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } tw_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/tw_bus_edge.sv
module tw_bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o = scl_q & scl_i & sda_q & ~sda_i;
    stop_o  = scl_q & scl_i & ~sda_q & sda_i;
    rise_o  = ~scl_q & scl_i;
    fall_o  = scl_q & ~scl_i;
  end
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             inc_i,
  input  logic             blk_we_i,
  input  logic             blk_val_i,
  output logic [PTR_W:0]   addr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             blk_q, blk_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)     ptr_d = load_val_i;
    else if (inc_i) ptr_d = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
    blk_d = blk_we_i ? blk_val_i : blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      blk_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      blk_q <= blk_d;
    end
  end

  assign addr_o = {blk_q, ptr_q};

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && !blk_we_i && ptr_q == {PTR_W{1'b1}}) |=> (ptr_q == '0 && $stable(blk_q))); // R10
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int         PTR_W     = 8,
  parameter bit         TWO_BLOCK = 1'b1,
  parameter logic [3:0] DEV_CODE  = 4'b1010
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  input  logic [2:0]     strap_i,
  input  logic           prog_busy_i,
  output logic [PTR_W:0] mem_addr_o,
  input  logic [7:0]     mem_rdata_i,
  output logic           wr_valid_o,
  output logic [7:0]     wr_data_o,
  output logic           wr_end_o
);
  import tw_pkg::*;

  localparam logic [2:0] CS_MASK = TWO_BLOCK ? 3'b110 : 3'b111;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic start_c, stop_c, rise_c, fall_c;
  tw_state_e st_q, st_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic rw_q, rw_d, mack_q, mack_d, wrote_q, wrote_d;
  logic ptr_load, ptr_inc, blk_we, wr_valid, wr_end;
  logic rx_state, rx_done, ctrl_hit, blk_sel;

  tw_bus_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_c), .stop_o(stop_c), .rise_o(rise_c), .fall_o(fall_c)
  );

  tw_addr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load_i(ptr_load), .load_val_i(sh_q[PTR_W-1:0]), .inc_i(ptr_inc),
    .blk_we_i(blk_we), .blk_val_i(blk_sel), .addr_o(mem_addr_o)
  );

  assign rx_state = (st_q == S_CTRL) || (st_q == S_ADDR) || (st_q == S_WDATA);
  assign rx_done  = rx_state && fall_c && (bit_q == LAST_BIT);
  assign ctrl_hit = (sh_q[7:4] == DEV_CODE) && (((sh_q[3:1] ^ strap_i) & CS_MASK) == 3'b000);
  assign blk_sel  = sh_q[1] & TWO_BLOCK;

  always_comb begin
    st_d = st_q; bit_d = bit_q; sh_d = sh_q;
    rw_d = rw_q; mack_d = mack_q; wrote_d = wrote_q;
    ptr_load = 1'b0; ptr_inc = 1'b0; blk_we = 1'b0;
    wr_valid = 1'b0; wr_end = 1'b0;
    if (stop_c) begin
      st_d = S_IDLE;
      wr_end = wrote_q;
      wrote_d = 1'b0;
    end else if (start_c) begin
      st_d = S_CTRL;
      bit_d = 4'd0;
    end else begin
      case (st_q)
        S_CTRL, S_ADDR, S_WDATA: begin
          if (rise_c && bit_q != LAST_BIT) begin
            sh_d  = {sh_q[6:0], sda_i};
            bit_d = bit_q + 4'd1;
          end else if (rx_done) begin
            bit_d = 4'd0;
            if (prog_busy_i) st_d = S_IGNORE;
            else if (st_q == S_CTRL) begin
              if (ctrl_hit) begin
                st_d = S_CTRL_ACK;
                rw_d = sh_q[0];
                blk_we = 1'b1;
              end else st_d = S_IGNORE;
            end else if (st_q == S_ADDR) begin
              st_d = S_ADDR_ACK;
              ptr_load = 1'b1;
            end else begin
              st_d = S_DATA_ACK;
              wr_valid = 1'b1;
              ptr_inc = 1'b1;
              wrote_d = 1'b1;
            end
          end
        end
        S_CTRL_ACK: if (fall_c) begin
          if (rw_q) begin
            sh_d = mem_rdata_i;
            ptr_inc = 1'b1;
            st_d = S_RDATA;
          end else st_d = S_ADDR;
        end
        S_ADDR_ACK, S_DATA_ACK: if (fall_c) st_d = S_WDATA;
        S_RDATA: if (fall_c) begin
          if (bit_q == LAST_BIT - 4'd1) begin
            bit_d = 4'd0;
            st_d = S_RACK;
          end else begin
            sh_d = {sh_q[6:0], 1'b0};
            bit_d = bit_q + 4'd1;
          end
        end
        S_RACK: begin
          if (rise_c) mack_d = ~sda_i;
          else if (fall_c) begin
            if (mack_q) begin
              sh_d = mem_rdata_i;
              ptr_inc = 1'b1;
              st_d = S_RDATA;
            end else st_d = S_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bit_q <= 4'd0; sh_q <= 8'h00;
      rw_q <= 1'b0; mack_q <= 1'b0; wrote_q <= 1'b0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; sh_q <= sh_d;
      rw_q <= rw_d; mack_q <= mack_d; wrote_q <= wrote_d;
    end
  end

  assign sda_oe = (st_q == S_CTRL_ACK) || (st_q == S_ADDR_ACK) || (st_q == S_DATA_ACK) ||
                  ((st_q == S_RDATA) && !sh_q[7]);
  assign wr_valid_o = wr_valid;
  assign wr_data_o  = sh_q;
  assign wr_end_o   = wr_end;

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st_q == S_IDLE && !sda_oe)); // R1
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !scl_i); // R3
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && prog_busy_i && !start_c && !stop_c) |=> !sda_oe); // R5
  AST_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && st_q == S_CTRL && !ctrl_hit && !start_c && !stop_c) |=> (!sda_oe && st_q == S_IGNORE)); // R6
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o); // R7
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RACK && fall_c && !mack_q && !start_c && !stop_c) |=> !sda_oe); // R8
endmodule

// File: tb/tw_eeprom_slave_tb.sv
module tw_eeprom_slave_tb;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b011;
  logic busy = 1'b0;
  logic sda_oe, wr_valid, wr_end;
  logic [8:0] mem_addr;
  logic [7:0] wr_data, mem_rdata;
  wire sda_line = m_sda & ~sda_oe;

  logic [7:0] mem [0:511];
  logic [7:0] exp_mem [0:511];
  logic [8:0] cap_addr [0:7];
  logic [7:0] cap_data [0:7];
  int wr_cnt = 0, end_cnt = 0, r3_viol = 0;
  int n_chk = 0, n_fail = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  tw_eeprom_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .prog_busy_i(busy), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .wr_end_o(wr_end)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (wr_valid) begin
      mem[mem_addr] <= wr_data;
      cap_addr[wr_cnt % 8] <= mem_addr;
      cap_data[wr_cnt % 8] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (wr_end) end_cnt <= end_cnt + 1;
    if (rst_n && sda_oe !== oe_prev && scl) r3_viol <= r3_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic hp; repeat (HP) @(negedge clk); endtask
  task automatic m_start; m_sda = 1'b1; hp; scl = 1'b1; hp; m_sda = 1'b0; hp; scl = 1'b0; hp; endtask
  task automatic m_stop; m_sda = 1'b0; hp; scl = 1'b1; hp; m_sda = 1'b1; hp; endtask
  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; hp; scl = 1'b1; hp; s = sda_line; hp; scl = 1'b0;
  endtask
  task automatic tx_byte(input [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask
  task automatic rx_byte(input logic give_ack, output [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~give_ack, s);
  endtask

  function automatic [7:0] ctrl(input logic blk, input logic rd);
    return {4'b1010, 2'b01, blk, rd};
  endfunction

  task automatic wr_seq(input logic blk, input [7:0] a, input int n);
    logic ack;
    logic [7:0] d;
    m_start;
    tx_byte(ctrl(blk, 1'b0), ack); chk("R4 ctrl ack", ack, 1);
    tx_byte(a, ack); chk("R4 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      tx_byte(d, ack); chk("R4 data ack", ack, 1);
      exp_mem[{blk, 8'(a + 8'(i))}] = d;
    end
    m_stop;
  endtask

  task automatic rd_seq(input logic blk, input [7:0] a, input int n);
    logic ack;
    logic [7:0] d;
    m_start;
    tx_byte(ctrl(blk, 1'b0), ack);
    tx_byte(a, ack);
    m_start;
    tx_byte(ctrl(blk, 1'b1), ack); chk("R9 read ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rx_byte(i != n - 1, d);
      chk("R8 read data", d, exp_mem[{blk, 8'(a + 8'(i))}]);
    end
    m_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int w0, e0;
    void'($urandom(32'd7331));
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (5) @(negedge clk);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R7 reset wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    hp;

    // R7 R12: write three bytes, check strobes
    w0 = wr_cnt; e0 = end_cnt;
    wr_seq(1'b0, 8'h20, 3);
    hp;
    chk("R7 strobe count", wr_cnt - w0, 3);
    chk("R7 first addr", cap_addr[w0 % 8], 9'h020);
    chk("R7 third addr", cap_addr[(w0 + 2) % 8], 9'h022);
    chk("R7 third data", cap_data[(w0 + 2) % 8], exp_mem[9'h022]);
    chk("R12 end pulse", end_cnt - e0, 1);

    // R8 R9: random read and current-address read
    rd_seq(1'b0, 8'h20, 3);
    m_start; tx_byte(ctrl(1'b0, 1'b1), ack); chk("R9 current read ack", ack, 1);
    rx_byte(1'b0, d); chk("R9 current read data", d, exp_mem[9'h023]);
    hp; chk("R8 released after nack", sda_oe, 0);
    m_stop;

    // R12: address-only frame has no end pulse
    e0 = end_cnt;
    m_start; tx_byte(ctrl(1'b0, 1'b0), ack); tx_byte(8'h40, ack); m_stop; hp;
    chk("R12 no end pulse", end_cnt - e0, 0);

    // R10 R11: wrap inside block 1 on write, block 0 on read
    w0 = wr_cnt;
    wr_seq(1'b1, 8'hFF, 2);
    hp;
    chk("R10 wrap addr a", cap_addr[w0 % 8], 9'h1FF);
    chk("R10 wrap addr b", cap_addr[(w0 + 1) % 8], 9'h100);
    rd_seq(1'b0, 8'hFF, 2);
    rd_seq(1'b1, 8'hFF, 2);

    // R11: strap bit 0 ignored
    strap = 3'b010;
    m_start; tx_byte(ctrl(1'b1, 1'b0), ack); chk("R11 strap0 ignored", ack, 1); m_stop;
    strap = 3'b011;

    // R5: busy blocks ack and writes
    busy = 1'b1; w0 = wr_cnt;
    m_start; tx_byte(ctrl(1'b0, 1'b0), ack); chk("R5 busy no ack", ack, 0);
    tx_byte(8'h10, ack); chk("R5 busy next no ack", ack, 0);
    tx_byte(8'h99, ack); m_stop; hp;
    chk("R5 no strobe", wr_cnt - w0, 0);
    busy = 1'b0;
    m_start; tx_byte(ctrl(1'b0, 1'b0), ack); chk("R5 ack after busy", ack, 1); m_stop;

    // R6 R2: mismatch and wrong device code
    w0 = wr_cnt;
    m_start; tx_byte({4'b1010, 2'b11, 1'b0, 1'b0}, ack); chk("R6 mismatch no ack", ack, 0);
    tx_byte(8'h05, ack); chk("R6 ignored byte", ack, 0);
    tx_byte(8'h77, ack); chk("R6 ignored data", ack, 0); m_stop; hp;
    chk("R6 no strobe", wr_cnt - w0, 0);
    m_start; tx_byte({4'b0110, 2'b01, 1'b0, 1'b0}, ack); chk("R2 bad code no ack", ack, 0); m_stop;

    // R1: start in mid-byte restarts control reception
    m_start; clk_bit(1'b1, d[0]); clk_bit(1'b0, d[0]); clk_bit(1'b1, d[0]);
    m_start; tx_byte(ctrl(1'b0, 1'b0), ack); chk("R1 restart ack", ack, 1);
    m_stop; hp; chk("R1 stop releases", sda_oe, 0);

    // random mix
    for (int it = 0; it < 16; it++) begin
      logic b;
      logic [7:0] a;
      int n;
      b = 1'($urandom);
      a = 8'($urandom);
      n = 1 + int'($urandom % 4);
      wr_seq(b, a, n);
      rd_seq(b, a, n);
    end

    hp;
    chk("R3 no oe change while scl high", r3_viol, 0);
    summary;
  end
endmodule